// File: doc/BRIEF.md
# Pulse-Swallow Divider Control

This block is the programmable counter pair that sits after an external dual-modulus prescaler in a frequency synthesizer loop. The prescaler output comes in on `presc_in`. The block samples that signal in the system clock domain and turns each rising edge into a single count event. Each event decrements a 7-bit swallow counter and a 10-bit main counter together. While the swallow counter is nonzero, `mod_sel` asks the prescaler for its larger ratio. Once the swallow counter has run out, `mod_sel` switches to the smaller ratio. The overall division is therefore set by both counters together, not by a single reload value.

The main counter sets the period. When it runs down, both counters take their preset values from `swallow_val` and `main_val`, `mod_sel` drops back to the larger ratio, and `div_out` pulses high for one clock. The preset inputs are the held latch values from the programming side. They are read only at a reload, so changing them partway through a cycle cannot disturb that cycle. `cfg_bad` reports a preset pair that cannot give a proper swallow sequence.

Top module: `pswallow_ctrl`

## Requirements
- R1: A rising edge of `presc_in` is counted as one event. If `presc_in` is first sampled high at clock edge k, after being sampled low at edge k-1, the counters and `div_out` update at edge k+2. High and low phases of one clock or longer are each counted. A level held high gives no further events.
- R2: Under synchronous active-low reset, both counters clear to zero, `div_out` is 0, `cfg_bad` is 0 and `mod_sel` is 1. The first event after reset performs a reload.
- R3: An event with the main counter at 2 or above decrements it by one. An event with the main counter at 1 or 0 reloads it. With a preset N of 2 or more, reloads therefore come exactly N events apart.
- R4: `div_out` is 1 for exactly the one clock that follows each reload, and 0 at all other times.
- R5: `mod_sel` is 0 (larger prescaler ratio) while the swallow counter is nonzero and 1 once it reaches zero. The swallow counter decrements on every non-reload event until it reaches zero, then holds at zero until the next reload. After a reload with preset A, `mod_sel` stays 0 for the next A events.
- R6: `swallow_val` and `main_val` are taken only at a reload. Changing them between reloads leaves the current cycle's length and modulus pattern unchanged.
- R7: One clock after `swallow_val` > `main_val` or `main_val` < 3 holds, `cfg_bad` is 1. Otherwise it is 0.
- R8: A preset swallow value of 0 keeps `mod_sel` at 1 for the whole cycle.
- R9: Without a count event, neither counter changes and `div_out` stays 0, whatever the preset inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_in | input | 1 | Prescaler output, asynchronous to `clk` |
| swallow_val | input | 7 | Preset for the swallow (A) counter |
| main_val | input | 10 | Preset for the main (N) counter |
| mod_sel | output | 1 | 0 selects the larger prescaler ratio, 1 the smaller |
| div_out | output | 1 | One-clock pulse per completed division cycle |
| cfg_bad | output | 1 | Preset pair is invalid (A > N or N < 3) |

## Verification
On every clock, the embedded assertions check several local rules. Count events are never back to back. A counter moves only on an event, and by exactly one. The swallow counter stays parked at zero. A reload loads the main preset and raises a single-clock `div_out` together with `mod_sel` low. The properties that span a whole cycle can only be shown by the bench's scenarios, which compare every clock against a behavioural model. These are the reload spacing of N events, the count of larger-ratio events per cycle, presets changed mid-cycle taking effect only at the following reload, a zero swallow preset, the edge-to-output latency, and irregular input widths.

// File: rtl/pswallow_pkg.sv
// Shared constants and types for the pulse-swallow divider control.
// Assumes: the consumer agrees that mod_sel low means the larger ratio.
package pswallow_pkg;

    // Smallest main-counter preset that still gives a proper cycle.
    localparam int MAIN_MIN_DEFAULT = 3;

    // Encoding of the prescaler ratio request.
    typedef enum logic {
        RATIO_LARGE = 1'b0,
        RATIO_SMALL = 1'b1
    } ratio_e;

endpackage

// File: rtl/pswallow_edge.sv
// Brings the asynchronous prescaler output into the clk domain and emits a
// one-clock event for each rising edge.
// Assumes: STAGES >= 1 and input phases of at least one clk period.
module pswallow_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single sampling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            // Shift the input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign evt = sync_q[STAGES-1] & ~prev_q;

    AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R1

endmodule

// File: rtl/pswallow_counter.sv
// Loadable down-counter. HOLD_AT_ZERO=1 parks the count at zero, so that
// further decrements are ignored; HOLD_AT_ZERO=0 lets it wrap.
// Assumes: load takes priority over dec.
module pswallow_counter #(
    parameter int W            = 8,
    parameter bit HOLD_AT_ZERO = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);

    logic dec_ok;

    generate
        if (HOLD_AT_ZERO) begin : g_hold
            assign dec_ok = dec && (cnt != '0);
        end else begin : g_wrap
            assign dec_ok = dec;
        end
    endgenerate

    // Load, step down, or keep the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (dec_ok) cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt)); // R9

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - W'(1))); // R3

    generate
        if (HOLD_AT_ZERO) begin : g_hold_chk
            AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (zero && !load) |=> zero); // R5
        end
    endgenerate

endmodule

// File: rtl/pswallow_cfg.sv
// Registers a flag for preset pairs that cannot produce a valid swallow
// sequence: swallow preset above main preset, or main preset below MAIN_MIN.
// Assumes: presets are static or slowly changing latch values.
module pswallow_cfg #(
    parameter int A_W      = 7,
    parameter int N_W      = 10,
    parameter int MAIN_MIN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_val,
    input  logic [N_W-1:0] n_val,
    output logic           bad
);

    localparam int CW = (A_W > N_W) ? A_W : N_W;

    logic [CW-1:0] a_ext;
    logic [CW-1:0] n_ext;
    logic          too_small;
    logic          a_over;

    assign a_ext     = CW'(a_val);
    assign n_ext     = CW'(n_val);
    assign too_small = (n_ext < CW'(MAIN_MIN));
    assign a_over    = (a_ext > n_ext);

    // Register the combined validity result.
    always_ff @(posedge clk) begin
        if (!rst_n) bad <= 1'b0;
        else        bad <= too_small | a_over;
    end

    AST_BAD_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        (n_val < N_W'(MAIN_MIN)) |=> bad); // R7

endmodule

// File: rtl/pswallow_ctrl.sv
// Pulse-swallow control for a dual-modulus prescaler: a swallow counter
// and a main counter that share one count event, a ratio request and a
// divided-output pulse.
// Assumes: presc_in phases last at least one clk period; presets are read
// only at reload.
module pswallow_ctrl
    import pswallow_pkg::*;
#(
    parameter int A_W         = 7,
    parameter int N_W         = 10,
    parameter int SYNC_STAGES = 2,
    parameter int MAIN_MIN    = MAIN_MIN_DEFAULT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           presc_in,
    input  logic [A_W-1:0] swallow_val,
    input  logic [N_W-1:0] main_val,
    output logic           mod_sel,
    output logic           div_out,
    output logic           cfg_bad
);

    logic           evt;
    logic           n_last;
    logic           reload;
    logic           step;
    logic [A_W-1:0] a_cnt;
    logic [N_W-1:0] n_cnt;
    logic           a_zero;
    logic           n_zero;
    ratio_e         ratio;

    pswallow_edge #(
        .STAGES(SYNC_STAGES)
    ) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (presc_in),
        .evt  (evt)
    );

    // Main counter at one or zero ends the cycle on the next event.
    assign n_last = (n_cnt <= N_W'(1));
    assign reload = evt & n_last;
    assign step   = evt & ~n_last;

    pswallow_counter #(
        .W           (A_W),
        .HOLD_AT_ZERO(1'b1)
    ) swallow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reload),
        .load_val(swallow_val),
        .dec     (step),
        .cnt     (a_cnt),
        .zero    (a_zero)
    );

    pswallow_counter #(
        .W           (N_W),
        .HOLD_AT_ZERO(1'b0)
    ) main_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reload),
        .load_val(main_val),
        .dec     (step),
        .cnt     (n_cnt),
        .zero    (n_zero)
    );

    pswallow_cfg #(
        .A_W     (A_W),
        .N_W     (N_W),
        .MAIN_MIN(MAIN_MIN)
    ) cfg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .a_val(swallow_val),
        .n_val(main_val),
        .bad  (cfg_bad)
    );

    // Ratio request follows the swallow counter state.
    assign ratio   = a_zero ? RATIO_SMALL : RATIO_LARGE;
    assign mod_sel = ratio;

    // One-clock divided output on each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) div_out <= 1'b0;
        else        div_out <= reload;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out); // R4

    AST_RELOAD_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (n_cnt == $past(main_val)) && div_out); // R6

    AST_RELOAD_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && swallow_val != '0) |=> !mod_sel); // R5

    AST_MAIN_NOT_ZERO_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !n_zero) |=> !n_zero); // R3

endmodule

// File: tb/pswallow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pswallow_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       presc_in;
    logic [6:0] swallow_val;
    logic [9:0] main_val;
    logic       mod_sel;
    logic       div_out;
    logic       cfg_bad;

    always #4 clk = ~clk;

    pswallow_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .presc_in   (presc_in),
        .swallow_val(swallow_val),
        .main_val   (main_val),
        .mod_sel    (mod_sel),
        .div_out    (div_out),
        .cfg_bad    (cfg_bad)
    );

    // Behavioural reference state.
    int    m_a, m_n;
    bit    m_pulse, m_err;
    bit    hist[$];
    string scen = "R2";
    int    vectors = 0, miscompares = 0, pulses = 0;
    bit    chk_en = 1'b0, done = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s (scenario %s): actual %0d expected %0d", req, scen, act, exp);
        end
    endtask

    // Reference model: history of samples, edge rule, counter behaviour.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_a = 0; m_n = 0; m_pulse = 0; m_err = 0;
        end else begin
            bit ev;
            ev = hist[1] && !hist[2];
            hist.push_front(presc_in);
            void'(hist.pop_back());
            m_pulse = 0;
            if (ev) begin
                if (m_n <= 1) begin
                    m_n = int'(main_val); m_a = int'(swallow_val); m_pulse = 1;
                end else begin
                    m_n = m_n - 1;
                    if (m_a > 0) m_a = m_a - 1;
                end
            end
            m_err = (int'(swallow_val) > int'(main_val)) || (main_val < 10'd3);
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (div_out) pulses++;
        if (chk_en && !done) begin
            check(mod_sel == (m_a == 0), "R5", int'(mod_sel), int'(m_a == 0));
            check(div_out == m_pulse, "R4", int'(div_out), int'(m_pulse));
            check(cfg_bad == m_err, "R7", int'(cfg_bad), int'(m_err));
        end
    end

    task automatic edges(int count, int hi, int lo);
        for (int i = 0; i < count; i++) begin
            presc_in = 1'b1;
            repeat (hi) @(negedge clk);
            presc_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; presc_in = 1'b0;
        swallow_val = 7'd3; main_val = 10'd10;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(mod_sel == 1'b1, "R2", int'(mod_sel), 1);
        check(div_out == 1'b0, "R2", int'(div_out), 0);
        check(cfg_bad == 1'b0, "R2", int'(cfg_bad), 0);
        chk_en = 1'b1;

        // R1: latency from first high sample to output
        scen = "R1";
        presc_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(div_out == 1'b0, "R1", int'(div_out), 0);
        @(negedge clk);
        check(div_out == 1'b1, "R1", int'(div_out), 1);
        presc_in = 1'b0;
        repeat (2) @(negedge clk);

        // R3: reload spacing of N events
        scen = "R3";
        pulses = 0;
        edges(30, 2, 2);
        check(pulses == 3, "R3", pulses, 3);

        // R6: presets changed mid-cycle apply only after the next reload
        scen = "R6";
        edges(4, 2, 2);
        swallow_val = 7'd1; main_val = 10'd5;
        pulses = 0;
        edges(5, 2, 2);
        check(pulses == 0, "R6", pulses, 0);
        edges(1, 2, 2);
        check(pulses == 1, "R6", pulses, 1);
        edges(5, 2, 2);
        check(pulses == 2, "R6", pulses, 2);

        // R8: zero swallow preset keeps the smaller ratio
        scen = "R8";
        swallow_val = 7'd0; main_val = 10'd4;
        edges(5, 1, 1);
        edges(2, 1, 2);
        check(mod_sel == 1'b1, "R8", int'(mod_sel), 1);

        // R9: level held high, presets changing, no events
        scen = "R9";
        presc_in = 1'b1;
        repeat (4) @(negedge clk);
        pulses = 0;
        begin
            logic mod_before;
            mod_before = mod_sel;
            for (int i = 0; i < 16; i++) begin
                swallow_val = 7'(i * 5); main_val = 10'(i * 3 + 1);
                @(negedge clk);
            end
            check(mod_sel == mod_before, "R9", int'(mod_sel), int'(mod_before));
            check(pulses == 0, "R9", pulses, 0);
        end
        presc_in = 1'b0;
        swallow_val = 7'd2; main_val = 10'd6;
        repeat (3) @(negedge clk);

        // R7: invalid preset pairs
        scen = "R7";
        swallow_val = 7'd20; main_val = 10'd10;
        repeat (2) @(negedge clk);
        check(cfg_bad == 1'b1, "R7", int'(cfg_bad), 1);
        swallow_val = 7'd0; main_val = 10'd2;
        repeat (2) @(negedge clk);
        check(cfg_bad == 1'b1, "R7", int'(cfg_bad), 1);
        swallow_val = 7'd3; main_val = 10'd3;
        repeat (2) @(negedge clk);
        check(cfg_bad == 1'b0, "R7", int'(cfg_bad), 0);
        edges(9, 1, 1);

        // R5: irregular widths and varied valid presets
        scen = "R5";
        for (int k = 0; k < 40; k++) begin
            int n;
            n = 3 + int'($urandom_range(0, 37));
            main_val = 10'(n);
            swallow_val = 7'($urandom_range(0, n));
            edges(int'($urandom_range(3, 12)), int'($urandom_range(1, 3)),
                  int'($urandom_range(1, 3)));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule